// File: doc/BRIEF.md
# Floating-Point Sign Operation Unit with Selectable NaN and Exception Semantics

This block performs the absolute-value and negate operations on a single-precision IEEE 754 operand. Two run-time mode bits in a small control register choose how it behaves. The first picks which value of the top fraction bit marks a NaN as quiet: the 2008 convention, or the older reversed one. The second picks between two ways of treating the operation. In bit-string mode only the sign bit changes, and no exception is ever raised. In arithmetic mode a signalling NaN operand raises Invalid Operation. That exception then either replaces the result with the default quiet NaN or, when its trap is enabled, asserts a trap request.

The datapath is combinational. The control register is updated on the rising clock edge and holds four bits:

| Bit | Meaning |
|-----|---------|
| 0 | Invalid trap enable |
| 1 | Sticky Invalid flag |
| 2 | NaN mode: 1 selects the 2008 convention, 0 the older one |
| 3 | Operation mode: 1 selects bit-string, 0 arithmetic |

Each of the two mode bits is set per build in one of four ways:
- writable, with reset value 0
- writable, with reset value 1
- read-only, fixed at 0
- read-only, fixed at 1

An integrating core sets these to match the NaN and exception semantics its software expects. It drives an operand and an opcode each cycle, and it receives the result, the flag and the trap request in the same cycle.

Top module: `fpsign_unit`

## Requirements
- R1: With NaN mode = 1, a NaN (exponent all ones, fraction nonzero) whose fraction bit 22 is 1 is quiet, and one whose fraction bit 22 is 0 is signalling.
- R2: With NaN mode = 0, the polarity is reversed: fraction bit 22 = 1 marks a signalling NaN and 0 marks a quiet NaN.
- R3: With operation mode = 1, ABS (op_neg=0) clears bit 31 and NEG (op_neg=1) inverts bit 31 for every operand, NaNs included. op_invalid and op_trap stay 0.
- R4: With operation mode = 0 and op_valid = 1, a signalling NaN operand raises op_invalid. A quiet NaN or a non-NaN operand gets only the sign change of R3 and raises nothing.
- R5: When Invalid is raised and the trap enable (bit 0) is 0, op_res is 0x7FC00000 in NaN mode 1 and 0x7FBFFFFF in NaN mode 0, and op_trap is 0.
- R6: When Invalid is raised and the trap enable is 1, op_trap is 1 and op_res is the sign-changed operand.
- R7: op_invalid sets bit 1 of the control register at the next rising edge. The bit stays 1 until a register write stores 0 there. If a write and an Invalid occur on the same edge, the bit becomes 1.
- R8: A register write (csr_we=1) updates bits 0 and 1 and every mode bit built as writable. A synchronous active-high reset clears bits 0 and 1 and loads each mode bit with its configured value.
- R9: A mode bit built as read-only reads as its fixed value at all times, and writes do not change it.
- R10: With op_valid = 0, op_invalid and op_trap are 0 and the sticky flag is not set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_we | input | 1 | Control register write strobe |
| csr_wdata | input | 4 | Control register write value |
| csr_rdata | output | 4 | Control register contents |
| op_valid | input | 1 | Operation issued this cycle |
| op_neg | input | 1 | 0 = ABS, 1 = NEG |
| op_a | input | 32 | Operand |
| op_res | output | 32 | Result |
| op_invalid | output | 1 | Invalid Operation raised this cycle |
| op_trap | output | 1 | Trap request |

## Verification
A mode bit holding the wrong value shows up within the same cycle. NaN operands near the classification boundary then come out with a swapped default NaN pattern, or with a flag where none is due. Mistakes in the sticky flag appear one edge later on csr_rdata, as a bit that fails to rise or that clears without a write. A read-only mode bit that accepts a write is visible on the first read after that write. The same error also changes how every later NaN operand is classified.

// File: rtl/fpsign_pkg.sv
package fpsign_pkg;
   localparam int CSR_W    = 4;
   localparam int IDX_TE   = 0;
   localparam int IDX_FLAG = 1;
   localparam int IDX_NAN  = 2;
   localparam int IDX_ABS  = 3;

   // configuration choices for a mode bit
   localparam int MB_RW0 = 0;
   localparam int MB_RW1 = 1;
   localparam int MB_HW0 = 2;
   localparam int MB_HW1 = 3;

   typedef enum logic {SOP_ABS = 1'b0, SOP_NEG = 1'b1} sop_e;
endpackage

// File: rtl/fpsign_modebit.sv
module fpsign_modebit #(
   parameter int CFG = 0
) (
   input  logic clk,
   input  logic rst,
   input  logic we,
   input  logic wbit,
   output logic q
);
   import fpsign_pkg::*;

   if (CFG < MB_RW0 || CFG > MB_HW1) begin : g_bad_cfg
      $error("fpsign_modebit: CFG out of range");
   end

   if (CFG == MB_HW0 || CFG == MB_HW1) begin : g_fixed
      logic unused_in;
      assign unused_in = ^{clk, rst, we, wbit};
      assign q = (CFG == MB_HW1);
   end else begin : g_writable
      logic bit_q;
      always_ff @(posedge clk) begin
         if (rst)     bit_q <= (CFG == MB_RW1);
         else if (we) bit_q <= wbit;
      end
      assign q = bit_q;
   end
endmodule

// File: rtl/fpsign_ctrl.sv
module fpsign_ctrl #(
   parameter int NAN_CFG = 0,
   parameter int ABS_CFG = 0
) (
   input  logic                        clk,
   input  logic                        rst,
   input  logic                        we,
   input  logic [fpsign_pkg::CSR_W-1:0] wdata,
   input  logic                        inv_set,
   output logic [fpsign_pkg::CSR_W-1:0] rdata,
   output logic                        trap_en,
   output logic                        nan2008,
   output logic                        abs2008
);
   import fpsign_pkg::*;

   logic te_q, flag_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         te_q   <= 1'b0;
         flag_q <= 1'b0;
      end else begin
         if (we) te_q <= wdata[IDX_TE];
         if (we)           flag_q <= wdata[IDX_FLAG] | inv_set;
         else if (inv_set) flag_q <= 1'b1;
      end
   end

   fpsign_modebit #(.CFG(NAN_CFG)) u_nan (
      .clk(clk), .rst(rst), .we(we), .wbit(wdata[IDX_NAN]), .q(nan2008));
   fpsign_modebit #(.CFG(ABS_CFG)) u_abs (
      .clk(clk), .rst(rst), .we(we), .wbit(wdata[IDX_ABS]), .q(abs2008));

   assign trap_en = te_q;
   always_comb begin
      rdata           = '0;
      rdata[IDX_TE]   = te_q;
      rdata[IDX_FLAG] = flag_q;
      rdata[IDX_NAN]  = nan2008;
      rdata[IDX_ABS]  = abs2008;
   end
endmodule

// File: rtl/fpsign_core.sv
module fpsign_core #(
   parameter int EXP_W  = 8,
   parameter int FRAC_W = 23,
   localparam int W     = 1 + EXP_W + FRAC_W
) (
   input  logic [W-1:0] a,
   input  logic         is_neg,
   input  logic         valid,
   input  logic         nan2008,
   input  logic         abs2008,
   input  logic         trap_en,
   output logic [W-1:0] res,
   output logic         invalid,
   output logic         trap_req
);
   import fpsign_pkg::*;

   logic [EXP_W-1:0]  ex;
   logic [FRAC_W-1:0] fr;
   logic              is_nan, top_frac, quiet, snan;
   logic [W-1:0]      sign_res, dflt_nan;
   sop_e              op;

   assign op       = sop_e'(is_neg);
   assign ex       = a[W-2 -: EXP_W];
   assign fr       = a[FRAC_W-1:0];
   assign is_nan   = (&ex) && (|fr);
   assign top_frac = fr[FRAC_W-1];
   assign quiet    = nan2008 ? top_frac : ~top_frac;
   assign snan     = is_nan & ~quiet;

   assign sign_res = (op == SOP_NEG) ? {~a[W-1], a[W-2:0]} : {1'b0, a[W-2:0]};
   assign dflt_nan = {1'b0, {EXP_W{1'b1}},
                      nan2008, {(FRAC_W-1){~nan2008}}};

   assign invalid  = valid & ~abs2008 & snan;
   assign trap_req = invalid & trap_en;
   assign res      = (invalid && !trap_en) ? dflt_nan : sign_res;
endmodule

// File: rtl/fpsign_unit.sv
module fpsign_unit #(
   parameter int EXP_W   = 8,
   parameter int FRAC_W  = 23,
   parameter int NAN_CFG = fpsign_pkg::MB_RW0,
   parameter int ABS_CFG = fpsign_pkg::MB_RW0,
   localparam int W      = 1 + EXP_W + FRAC_W
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         csr_we,
   input  logic [3:0]   csr_wdata,
   output logic [3:0]   csr_rdata,
   input  logic         op_valid,
   input  logic         op_neg,
   input  logic [W-1:0] op_a,
   output logic [W-1:0] op_res,
   output logic         op_invalid,
   output logic         op_trap
);
   import fpsign_pkg::*;

   if (EXP_W < 2 || FRAC_W < 2) begin : g_bad_fmt
      $error("fpsign_unit: exponent and fraction need at least 2 bits");
   end
   if (CSR_W != 4) begin : g_bad_csr
      $error("fpsign_unit: control register width mismatch");
   end

   logic trap_en, nan2008, abs2008;

   fpsign_ctrl #(.NAN_CFG(NAN_CFG), .ABS_CFG(ABS_CFG)) u_ctrl (
      .clk(clk), .rst(rst), .we(csr_we), .wdata(csr_wdata),
      .inv_set(op_invalid), .rdata(csr_rdata),
      .trap_en(trap_en), .nan2008(nan2008), .abs2008(abs2008));

   fpsign_core #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_core (
      .a(op_a), .is_neg(op_neg), .valid(op_valid),
      .nan2008(nan2008), .abs2008(abs2008), .trap_en(trap_en),
      .res(op_res), .invalid(op_invalid), .trap_req(op_trap));

   assert_bitstring_quiet_R3: assert property (@(posedge clk) disable iff (rst)
      abs2008 |-> (!op_invalid && !op_trap));
   assert_abs_sign_R3: assert property (@(posedge clk) disable iff (rst)
      (abs2008 && !op_neg) |-> !op_res[W-1]);
   assert_trap_gated_R6: assert property (@(posedge clk) disable iff (rst)
      op_trap |-> (op_invalid && csr_rdata[IDX_TE]));
   assert_idle_R10: assert property (@(posedge clk) disable iff (rst)
      !op_valid |-> (!op_invalid && !op_trap));
   assert_sticky_set_R7: assert property (@(posedge clk) disable iff (rst)
      op_invalid |=> csr_rdata[IDX_FLAG]);
   assert_sticky_hold_R7: assert property (@(posedge clk) disable iff (rst)
      $fell(csr_rdata[IDX_FLAG]) |-> $past(csr_we));
endmodule

// File: tb/sim_fpsign_unit.sv
module sim_fpsign_unit;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        csr_we = 1'b0;
   logic [3:0]  csr_wdata = '0;
   logic        op_valid = 1'b0, op_neg = 1'b0;
   logic [31:0] op_a = '0;
   logic [3:0]  rd0, rd1;
   logic [31:0] res0, res1;
   logic        inv0, inv1, trp0, trp1;
   int          checks = 0, errors = 0;
   bit          done = 0;
   // bench model of control state
   logic        m_te, m_flag0, m_flag1, m_nan0, m_abs0;

   always #2.5 clk = ~clk;   // 200 MHz

   fpsign_unit u0 (.clk(clk), .rst(rst), .csr_we(csr_we), .csr_wdata(csr_wdata),
      .csr_rdata(rd0), .op_valid(op_valid), .op_neg(op_neg), .op_a(op_a),
      .op_res(res0), .op_invalid(inv0), .op_trap(trp0));
   // NaN mode fixed at 1, operation mode fixed at 0
   fpsign_unit #(.NAN_CFG(3), .ABS_CFG(2)) u1 (.clk(clk), .rst(rst),
      .csr_we(csr_we), .csr_wdata(csr_wdata), .csr_rdata(rd1),
      .op_valid(op_valid), .op_neg(op_neg), .op_a(op_a),
      .op_res(res1), .op_invalid(inv1), .op_trap(trp1));

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic is_snan(logic [31:0] a, logic nan);
      logic n;
      n = (&a[30:23]) && (|a[22:0]);
      return n && (nan ? !a[22] : a[22]);
   endfunction

   function automatic logic e_inv(logic [31:0] a, logic v, logic nan, logic absm);
      return v && !absm && is_snan(a, nan);
   endfunction

   function automatic logic [31:0] e_res(logic [31:0] a, logic neg, logic v,
                                         logic nan, logic absm, logic te);
      logic [31:0] s;
      s = neg ? {~a[31], a[30:0]} : {1'b0, a[30:0]};
      if (e_inv(a, v, nan, absm) && !te) return nan ? 32'h7FC00000 : 32'h7FBFFFFF;
      return s;
   endfunction

   task automatic set_csr(logic [3:0] v);
      @(negedge clk);
      op_valid = 1'b0; csr_we = 1'b1; csr_wdata = v;
      @(negedge clk);
      csr_we = 1'b0;
      m_te = v[0]; m_flag0 = v[1]; m_flag1 = v[1]; m_nan0 = v[2]; m_abs0 = v[3];
      chk("R8 u0 write", {28'd0, rd0}, {28'd0, m_abs0, m_nan0, m_flag0, m_te});
      chk("R9 u1 read-only bits", {28'd0, rd1}, {28'd0, 1'b0, 1'b1, m_flag1, m_te});
   endtask

   task automatic do_op(string tag, logic [31:0] a, logic neg, logic v);
      logic ei0, ei1;
      @(negedge clk);
      op_a = a; op_neg = neg; op_valid = v;
      #1;
      ei0 = e_inv(a, v, m_nan0, m_abs0);
      ei1 = e_inv(a, v, 1'b1, 1'b0);
      chk({tag, " u0 res"}, res0, e_res(a, neg, v, m_nan0, m_abs0, m_te));
      chk({tag, " u0 invalid"}, {31'd0, inv0}, {31'd0, ei0});
      chk({tag, " R6 u0 trap"}, {31'd0, trp0}, {31'd0, ei0 & m_te});
      chk({tag, " u1 res"}, res1, e_res(a, neg, v, 1'b1, 1'b0, m_te));
      chk({tag, " u1 invalid"}, {31'd0, inv1}, {31'd0, ei1});
      if (ei0) m_flag0 = 1'b1;
      if (ei1) m_flag1 = 1'b1;
      @(negedge clk);
      op_valid = 1'b0;
      chk("R7 u0 sticky flag", {31'd0, rd0[1]}, {31'd0, m_flag0});
      chk("R7 u1 sticky flag", {31'd0, rd1[1]}, {31'd0, m_flag1});
   endtask

   function automatic logic [31:0] rand_op();
      logic [31:0] r;
      r = $urandom;
      case ($urandom % 4)
         0: return r;
         1: return {r[31], 8'hFF, r[22:1], 1'b1};
         2: return {r[31], 8'hFF, r[22], 22'd0} | 32'h1;
         default: return {r[31], 8'hFF, 23'd0};
      endcase
   endfunction

   initial begin
      void'($urandom(32'd1357));
      m_te = 0; m_flag0 = 0; m_flag1 = 0; m_nan0 = 0; m_abs0 = 0;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      chk("R8 u0 reset", {28'd0, rd0}, 32'h0);
      chk("R8 u1 reset", {28'd0, rd1}, 32'h4);

      // R2: legacy mode, arithmetic, trap off
      do_op("R2 legacy snan", 32'h7FC00000, 1'b0, 1'b1);
      chk("R5 legacy default NaN", res0, 32'h7FBFFFFF);
      do_op("R2 legacy qnan", 32'hFF800001, 1'b1, 1'b1);
      // R10: not valid
      do_op("R10 idle snan", 32'h7FC00000, 1'b1, 1'b0);
      set_csr(4'b0000);
      // R1: 2008 mode
      set_csr(4'b0100);
      do_op("R1 2008 snan", 32'hFF800001, 1'b0, 1'b1);
      chk("R5 2008 default NaN", res0, 32'h7FC00000);
      do_op("R1 2008 qnan", 32'hFFC00000, 1'b0, 1'b1);
      do_op("R4 infinity", 32'hFF800000, 1'b1, 1'b1);
      // R6: trap enabled
      set_csr(4'b0101);
      do_op("R6 trap", 32'h7F800001, 1'b1, 1'b1);
      chk("R6 sign-changed result", res0, 32'hFF800001);
      // R7: clear via write
      set_csr(4'b0100);
      // R3: bit-string mode, NaNs included
      set_csr(4'b1001);
      do_op("R3 abs snan", 32'hFFC00001, 1'b0, 1'b1);
      do_op("R3 neg snan", 32'h7FC00001, 1'b1, 1'b1);
      do_op("R3 neg zero", 32'h00000000, 1'b1, 1'b1);

      for (int i = 0; i < 600; i++) begin
         if (i % 25 == 0) set_csr(4'($urandom) & 4'b1101);
         do_op("R4 random", rand_op(), 1'($urandom), ($urandom % 8) != 0);
      end
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule